// File: doc/BRIEF.md
# Masked Packed Unsigned Multiply-High Unit

This execution unit takes two 512-bit source vectors, treats them as thirty-two unsigned 16-bit lanes, and multiplies each pair into a full 32-bit product. Only the upper half of each product goes back to the lane. The result is combined with the previous destination value. How much of that old value survives depends on three things: the selected vector length, the encoding mode (legacy, VEX or EVEX), and, in EVEX mode, a per-lane write mask with either merge or zero behaviour.

A request is presented with `in_valid` together with its operands and controls. One clock later the unit presents the new destination with `out_valid`. A request whose encoding and length cannot go together is flagged on `out_err`, and the old destination is returned unchanged. The unit updates no flags and raises no numeric exceptions.

The output side is a three-state machine:
- `ST_IDLE`: no result is presented.
- `ST_DONE`: a legal result is presented.
- `ST_FAULT`: an illegal request is being reported.

From every state the transitions are the same:
- A legal request goes to `ST_DONE`.
- An illegal request goes to `ST_FAULT`.
- A cycle without a request goes to `ST_IDLE`.
- Synchronous reset forces `ST_IDLE`.

Top module: `mulhi_lane_unit`

## Requirements
- R1: Each active lane that is written receives bits 31:16 of the unsigned 32-bit product of its two 16-bit operands, so 0xFFFF times 0xFFFF gives 0xFFFE.
- R2: Lane j occupies bits 16*j+15:16*j. The `vl_sel` codes 0, 1, 2 and 3 select 4, 8, 16 and 32 active lanes.
- R3: In legacy mode (`enc_sel`=0, legal only with `vl_sel` 0 or 1), lanes above the active count keep their previous value, and every active lane is written.
- R4: In VEX mode (`enc_sel`=1, legal only with `vl_sel` 1 or 2), lanes above the active count become zero, and every active lane is written.
- R5: In EVEX mode (`enc_sel`=2, legal with `vl_sel` 1, 2 or 3), an active lane with its `lane_mask` bit set is written. An active lane with its bit clear keeps its old value when `zero_mask`=0 and becomes zero when `zero_mask`=1. Lanes above the active count become zero.
- R6: `mask_off`=1 makes EVEX write every active lane whatever the mask holds. Mask bits above the active count, and the whole mask in legacy and VEX modes, have no effect.
- R7: An illegal request raises `out_err` with `out_valid`, and `out_dest` equals the previous destination input. The illegal requests are `enc_sel`=3, legacy with `vl_sel` 2 or 3, VEX with `vl_sel` 0 or 3, and EVEX with `vl_sel` 0.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and `out_dest` and `out_err` change only then. Synchronous reset clears `out_valid`, `out_err` and `out_dest`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| old_dest | input | 512 | Previous destination value |
| lane_mask | input | 32 | Per-lane write mask (EVEX) |
| mask_off | input | 1 | Treat the request as unmasked |
| vl_sel | input | 2 | Vector length: 0=64, 1=128, 2=256, 3=512 bits |
| enc_sel | input | 2 | Encoding mode: 0=legacy, 1=VEX, 2=EVEX, 3=reserved |
| zero_mask | input | 1 | 1 = zero masking, 0 = merge masking |
| out_valid | output | 1 | Result strobe |
| out_dest | output | 512 | New destination value |
| out_err | output | 1 | Illegal request reported |

## Verification
The hardest situation to reach from the ports is a masked EVEX request whose mask bits are set only in lanes at and above the active count. The mask must then have no visible effect, and the outcome differs between merge and zero masking only in the lanes below that boundary. The stimulus reaches it directly: it builds masks that are set purely above the boundary and masks that alternate across it, and it sends both masking styles with the same data. Illegal requests are sent back to back with legal ones. This shows that the fault state can be left in one cycle and that the returned destination is the old value, not the last product.

// File: rtl/mulhi_pkg.sv
package mulhi_pkg;

    typedef enum logic [1:0] {
        VL_64  = 2'd0,
        VL_128 = 2'd1,
        VL_256 = 2'd2,
        VL_512 = 2'd3
    } vlen_e;

    typedef enum logic [1:0] {
        ENC_LEGACY = 2'd0,
        ENC_VEX    = 2'd1,
        ENC_EVEX   = 2'd2,
        ENC_RSVD   = 2'd3
    } enc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2
    } out_state_e;

endpackage

// File: rtl/mulhi_ctrl.sv
module mulhi_ctrl
    import mulhi_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [1:0]       vl_sel,
    input  logic [1:0]       enc_sel,
    input  logic             mask_off,
    input  logic             zero_mask,
    output logic             legal,
    output logic [LANES-1:0] lane_act,
    output logic             keep_upper,
    output logic             use_mask,
    output logic             zero_fill
);
    localparam int MIN_LANES = LANES / 8;
    localparam int CNT_W     = $clog2(LANES) + 2;

    vlen_e              vl;
    enc_e               enc;
    logic [CNT_W-1:0]   act_cnt;

    assign vl      = vlen_e'(vl_sel);
    assign enc     = enc_e'(enc_sel);
    assign act_cnt = CNT_W'(MIN_LANES) << vl_sel;

    always_comb begin
        unique case (enc)
            ENC_LEGACY: legal = (vl == VL_64) || (vl == VL_128);
            ENC_VEX:    legal = (vl == VL_128) || (vl == VL_256);
            ENC_EVEX:   legal = (vl != VL_64);
            default:    legal = 1'b0;
        endcase
    end

    genvar j;
    generate
        for (j = 0; j < LANES; j++) begin : g_act
            assign lane_act[j] = (CNT_W'(j) < act_cnt);
        end
    endgenerate

    assign keep_upper = (enc == ENC_LEGACY);
    assign use_mask   = (enc == ENC_EVEX) && !mask_off;
    assign zero_fill  = (enc == ENC_EVEX) && zero_mask;

endmodule

// File: rtl/mulhi_lane.sv
module mulhi_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] old,
    input  logic         active,
    input  logic         wr_en,
    input  logic         zero_fill,
    input  logic         keep_upper,
    output logic [W-1:0] res
);
    logic [2*W-1:0] prod;
    logic [W-1:0]   hi;

    assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    assign hi   = prod[2*W-1:W];

    always_comb begin
        if (!active)
            res = keep_upper ? old : '0;
        else if (wr_en)
            res = hi;
        else
            res = zero_fill ? '0 : old;
    end

endmodule

// File: rtl/mulhi_lane_unit.sv
module mulhi_lane_unit
    import mulhi_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int LANE_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [LANES*LANE_W-1:0]   src_a,
    input  logic [LANES*LANE_W-1:0]   src_b,
    input  logic [LANES*LANE_W-1:0]   old_dest,
    input  logic [LANES-1:0]          lane_mask,
    input  logic                      mask_off,
    input  logic [1:0]                vl_sel,
    input  logic [1:0]                enc_sel,
    input  logic                      zero_mask,
    output logic                      out_valid,
    output logic [LANES*LANE_W-1:0]   out_dest,
    output logic                      out_err
);
    localparam int VEC_W = LANES * LANE_W;

    logic             legal;
    logic [LANES-1:0] lane_act;
    logic             keep_upper;
    logic             use_mask;
    logic             zero_fill;
    logic [VEC_W-1:0] lane_vec;
    logic [VEC_W-1:0] next_vec;
    logic [VEC_W-1:0] dest_q;

    out_state_e state_q;
    out_state_e state_d;

    mulhi_ctrl #(.LANES(LANES)) u_ctrl (
        .vl_sel     (vl_sel),
        .enc_sel    (enc_sel),
        .mask_off   (mask_off),
        .zero_mask  (zero_mask),
        .legal      (legal),
        .lane_act   (lane_act),
        .keep_upper (keep_upper),
        .use_mask   (use_mask),
        .zero_fill  (zero_fill)
    );

    genvar j;
    generate
        for (j = 0; j < LANES; j++) begin : g_lane
            mulhi_lane #(.W(LANE_W)) u_lane (
                .a          (src_a[j*LANE_W +: LANE_W]),
                .b          (src_b[j*LANE_W +: LANE_W]),
                .old        (old_dest[j*LANE_W +: LANE_W]),
                .active     (lane_act[j]),
                .wr_en      (!use_mask || lane_mask[j]),
                .zero_fill  (zero_fill),
                .keep_upper (keep_upper),
                .res        (lane_vec[j*LANE_W +: LANE_W])
            );
        end
    endgenerate

    assign next_vec = legal ? lane_vec : old_dest;

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (in_valid)
                    state_d = legal ? ST_DONE : ST_FAULT;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // result register
    always_ff @(posedge clk) begin
        if (rst)
            dest_q <= '0;
        else if (in_valid)
            dest_q <= next_vec;
    end

    // outputs from state
    always_comb begin
        out_valid = 1'b0;
        out_err   = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin out_valid = 1'b0; out_err = 1'b0; end
            ST_DONE:  begin out_valid = 1'b1; out_err = 1'b0; end
            ST_FAULT: begin out_valid = 1'b1; out_err = 1'b1; end
            default:  begin out_valid = 1'b0; out_err = 1'b0; end
        endcase
    end

    assign out_dest = dest_q;

endmodule

// File: rtl/mulhi_unit_chk.sv
module mulhi_unit_chk #(
    parameter int LANES  = 32,
    parameter int LANE_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [LANES*LANE_W-1:0] old_dest,
    input logic [LANES-1:0]        lane_mask,
    input logic                    mask_off,
    input logic [1:0]              vl_sel,
    input logic [1:0]              enc_sel,
    input logic                    zero_mask,
    input logic                    out_valid,
    input logic [LANES*LANE_W-1:0] out_dest,
    input logic                    out_err
);
    localparam int VEC_W = LANES * LANE_W;
    localparam int HALF  = VEC_W / 4;

    logic bad_combo;
    assign bad_combo = (enc_sel == 2'd3)
                    || (enc_sel == 2'd0 && vl_sel[1])
                    || (enc_sel == 2'd1 && (vl_sel == 2'd0 || vl_sel == 2'd3))
                    || (enc_sel == 2'd2 && vl_sel == 2'd0);

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_err && out_dest == '0));

    p_err_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_valid);

    p_err_keeps_dest_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bad_combo) |=> (out_err && out_dest == $past(old_dest)));

    p_vex_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && enc_sel == 2'd1 && vl_sel == 2'd1)
        |=> (out_dest[VEC_W-1:HALF] == '0));

    p_legacy_upper_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && enc_sel == 2'd0 && vl_sel == 2'd1)
        |=> (out_dest[VEC_W-1:HALF] == $past(old_dest[VEC_W-1:HALF])));

    p_evex_zeroed_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && enc_sel == 2'd2 && vl_sel == 2'd3 && !mask_off
         && zero_mask && lane_mask == '0) |=> (out_dest == '0));

    p_evex_merge_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && enc_sel == 2'd2 && vl_sel == 2'd3 && !mask_off
         && !zero_mask && lane_mask == '0) |=> (out_dest == $past(old_dest)));

endmodule

bind mulhi_lane_unit mulhi_unit_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .old_dest  (old_dest),
    .lane_mask (lane_mask),
    .mask_off  (mask_off),
    .vl_sel    (vl_sel),
    .enc_sel   (enc_sel),
    .zero_mask (zero_mask),
    .out_valid (out_valid),
    .out_dest  (out_dest),
    .out_err   (out_err)
);

// File: tb/test_mulhi_lane_unit.sv
module test_mulhi_lane_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [511:0] src_a = '0;
    logic [511:0] src_b = '0;
    logic [511:0] old_dest = '0;
    logic [31:0]  lane_mask = '0;
    logic         mask_off = 1'b0;
    logic [1:0]   vl_sel = 2'd0;
    logic [1:0]   enc_sel = 2'd0;
    logic         zero_mask = 1'b0;
    logic         out_valid;
    logic [511:0] out_dest;
    logic         out_err;

    int    errors = 0;
    int    checks = 0;
    string cur_tag = "R8";

    // behavioural model state
    bit           m_live = 0;
    bit           m_valid = 0;
    bit           m_err = 0;
    logic [511:0] m_dest = '0;
    string        m_tag = "R8";

    always #10 clk = ~clk;

    mulhi_lane_unit i_mulhi_lane_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .old_dest(old_dest),
        .lane_mask(lane_mask), .mask_off(mask_off), .vl_sel(vl_sel),
        .enc_sel(enc_sel), .zero_mask(zero_mask),
        .out_valid(out_valid), .out_dest(out_dest), .out_err(out_err)
    );

    function automatic bit is_legal(int enc, int vl);
        if (enc == 0) return (vl == 0 || vl == 1);
        if (enc == 1) return (vl == 1 || vl == 2);
        if (enc == 2) return (vl != 0);
        return 0;
    endfunction

    function automatic logic [511:0] model(
        logic [511:0] a, logic [511:0] b, logic [511:0] old,
        logic [31:0] msk, bit moff, int vl, int enc, bit zm);
        logic [511:0] r;
        int active;
        active = 4 * (1 << vl);
        r = '0;
        for (int j = 0; j < 32; j++) begin
            int unsigned pa, pb, p;
            pa = a[16*j +: 16];
            pb = b[16*j +: 16];
            p  = pa * pb;
            if (j >= active) begin
                r[16*j +: 16] = (enc == 0) ? old[16*j +: 16] : 16'h0;
            end else if (enc != 2 || moff || msk[j]) begin
                r[16*j +: 16] = p[31:16];
            end else begin
                r[16*j +: 16] = zm ? 16'h0 : old[16*j +: 16];
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        m_live <= 1;
        m_tag  <= cur_tag;
        if (rst) begin
            m_valid <= 0;
            m_err   <= 0;
            m_dest  <= '0;
        end else if (in_valid) begin
            m_valid <= 1;
            if (is_legal(enc_sel, vl_sel)) begin
                m_err  <= 0;
                m_dest <= model(src_a, src_b, old_dest, lane_mask, mask_off,
                                vl_sel, enc_sel, zero_mask);
            end else begin
                m_err  <= 1;
                m_dest <= old_dest;
            end
        end else begin
            m_valid <= 0;
            m_err   <= 0;
        end
    end

    always @(negedge clk) begin
        if (m_live) begin
            checks++;
            if (out_valid !== m_valid || out_err !== m_err || out_dest !== m_dest) begin
                errors++;
                $display("FAIL %s: valid=%b err=%b dest=%h exp valid=%b err=%b dest=%h",
                         m_tag, out_valid, out_err, out_dest, m_valid, m_err, m_dest);
            end
        end
    end

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int k = 0; k < 16; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    task automatic drive(string tag, logic [511:0] a, logic [511:0] b,
                         logic [511:0] old, logic [31:0] msk, bit moff,
                         int vl, int enc, bit zm);
        @(negedge clk);
        cur_tag   = tag;
        in_valid  = 1'b1;
        src_a     = a;
        src_b     = b;
        old_dest  = old;
        lane_mask = msk;
        mask_off  = moff;
        vl_sel    = 2'(vl);
        enc_sel   = 2'(enc);
        zero_mask = zm;
    endtask

    task automatic idle(string tag, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cur_tag  = tag;
            in_valid = 1'b0;
            src_a    = rnd512();
            old_dest = rnd512();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R8: watchdog expired, actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        checks++;
        if (out_valid !== 1'b0 || out_err !== 1'b0 || out_dest !== '0) begin
            errors++;
            $display("FAIL R8: reset valid=%b err=%b dest=%h expected 0 0 0",
                     out_valid, out_err, out_dest);
        end
        rst = 1'b0;

        // R1: all-ones operands in every lane and a small known product
        drive("R1", {32{16'hFFFF}}, {32{16'hFFFF}}, rnd512(), '0, 0, 3, 2, 0);
        drive("R1", {32{16'h8000}}, {32{16'h0002}}, rnd512(), '0, 0, 1, 0, 0);
        drive("R1", {32{16'h1234}}, {32{16'h0000}}, rnd512(), '0, 0, 2, 1, 0);
        idle("R8", 1);

        // R2: lane placement over every legal length
        for (int e = 0; e < 3; e++)
            for (int v = 0; v < 4; v++)
                if (is_legal(e, v))
                    drive("R2", rnd512(), rnd512(), rnd512(), $urandom, 1, v, e, 0);

        // R3 legacy keep above length; R4 VEX zero above length
        drive("R3", rnd512(), rnd512(), {512{1'b1}}, '0, 0, 0, 0, 1);
        drive("R3", rnd512(), rnd512(), rnd512(), '0, 0, 1, 0, 0);
        drive("R4", rnd512(), rnd512(), {512{1'b1}}, '0, 0, 1, 1, 1);
        drive("R4", rnd512(), rnd512(), rnd512(), '0, 0, 2, 1, 0);

        // R5: merge versus zero masking on the same data
        for (int v = 1; v < 4; v++) begin
            logic [511:0] a, b, o;
            logic [31:0]  m;
            a = rnd512(); b = rnd512(); o = rnd512(); m = 32'hA5A5_3C69;
            drive("R5", a, b, o, m, 0, v, 2, 0);
            drive("R5", a, b, o, m, 0, v, 2, 1);
        end
        drive("R5", rnd512(), rnd512(), rnd512(), 32'h0, 0, 3, 2, 1);
        drive("R5", rnd512(), rnd512(), rnd512(), 32'h0, 0, 3, 2, 0);

        // R6: mask only above boundary, mask_off override, mask ignored outside EVEX
        drive("R6", rnd512(), rnd512(), rnd512(), 32'hFFFF_FF00, 0, 1, 2, 1);
        drive("R6", rnd512(), rnd512(), rnd512(), 32'hFFFF_FF00, 0, 1, 2, 0);
        drive("R6", rnd512(), rnd512(), rnd512(), 32'hFFFF_0000, 0, 2, 2, 0);
        drive("R6", rnd512(), rnd512(), rnd512(), 32'h0, 1, 3, 2, 1);
        drive("R6", rnd512(), rnd512(), rnd512(), 32'h0, 0, 2, 1, 1);
        drive("R6", rnd512(), rnd512(), rnd512(), 32'h0, 0, 1, 0, 1);

        // R7: every illegal pairing, interleaved with legal ones
        drive("R7", rnd512(), rnd512(), rnd512(), $urandom, 0, 2, 0, 0);
        drive("R7", rnd512(), rnd512(), rnd512(), $urandom, 0, 3, 0, 0);
        drive("R2", rnd512(), rnd512(), rnd512(), $urandom, 0, 3, 2, 0);
        drive("R7", rnd512(), rnd512(), rnd512(), $urandom, 0, 0, 1, 0);
        drive("R7", rnd512(), rnd512(), rnd512(), $urandom, 0, 3, 1, 0);
        drive("R7", rnd512(), rnd512(), rnd512(), $urandom, 1, 0, 2, 1);
        drive("R7", rnd512(), rnd512(), rnd512(), $urandom, 0, 1, 3, 0);
        idle("R8", 3);

        // R8: gaps between requests, held result across idle cycles
        for (int k = 0; k < 40; k++) begin
            drive("R8", rnd512(), rnd512(), rnd512(), $urandom,
                  1'($urandom), int'($urandom % 4), int'($urandom % 4), 1'($urandom));
            if (k % 3 == 0) idle("R8", 1 + k % 4);
        end

        // mixed random traffic
        for (int k = 0; k < 300; k++)
            drive("R5", rnd512(), rnd512(), rnd512(), $urandom,
                  1'($urandom % 4 == 0), int'($urandom % 4), int'($urandom % 4),
                  1'($urandom));

        // R8: reset mid-stream clears outputs
        drive("R8", rnd512(), rnd512(), rnd512(), '0, 0, 3, 2, 0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle("R8", 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule